// File: doc/BRIEF.md
# SPI Packed Short-Frame Datapath

This block is the transmit and receive datapath of an SPI master that moves frames of 4 to 8 bits. Each frame takes one byte of storage. A single 16-bit host access therefore carries two frames. The host pushes bytes into a transmit FIFO through an 8-bit or 16-bit write port. It pops received bytes from a receive FIFO through a read port of the same two widths.

The shift engine drains the transmit FIFO one frame at a time. It runs SCK with idle-low polarity and second-edge capture. MOSI changes on each rising edge, and MISO is captured on each falling edge. NSS is held low for as long as frames follow one another back to back.

A receive threshold selects whether the "data ready" flag means one stored byte or two. The host therefore sets it to match the width of its next read. To transmit an odd number of frames, the host writes the last frame with an 8-bit access. To receive an odd number, it switches to the one-byte threshold for the last frame.

Top module: `spi_pack_dp`

## Requirements
- R1: After reset, txe_o=1, rxne_o=0, ovr_o=0, nss_o=1 and sck_o=0.
- R2: A 16-bit write sends the byte in bits [7:0] first and the byte in bits [15:8] second.
- R3: Each frame shifts exactly cfg_dsz_i+1 bits, MSB first, starting at bit cfg_dsz_i of the stored byte. Bits above the frame size have no effect on MOSI. cfg_dsz_i holds the frame size minus one, with legal values 3 to 7.
- R4: A received frame is stored right-aligned, with zeros in every bit above the frame size.
- R5: A 16-bit read returns the earlier received frame in bits [7:0] and the later one in bits [15:8]. An 8-bit read returns the oldest frame in bits [7:0] and zeros in bits [15:8].
- R6: rxne_o is 1 when the receive FIFO holds at least one byte and cfg_rx_qtr_i=1. It is 1 when the FIFO holds at least two bytes and cfg_rx_qtr_i=0.
- R7: An 8-bit write pushes only bits [7:0], so a single frame is transmitted.
- R8: txe_o is 1 exactly when the transmit FIFO (DEPTH bytes, default 4) has room for at least two bytes.
- R9: A write whose bytes do not all fit into the transmit FIFO is dropped as a whole and never transmitted.
- R10: A frame received while the receive FIFO is full is discarded and sets ovr_o, which stays set until reset.
- R11: sck_o is low whenever nss_o is high. MOSI changes only on a rising SCK edge, and MISO is sampled on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_dsz_i | input | 4 | Frame size minus one (3..7) |
| cfg_rx_qtr_i | input | 1 | 1: one-byte receive threshold; 0: two-byte threshold |
| wr_en_i | input | 1 | Host write strobe |
| wr_wide_i | input | 1 | 1: 16-bit write, 0: 8-bit write |
| wr_data_i | input | 16 | Write data; bits [7:0] go first |
| rd_en_i | input | 1 | Host read strobe (pops bytes) |
| rd_wide_i | input | 1 | 1: 16-bit read, 0: 8-bit read |
| rd_data_o | output | 16 | Read data from the head of the receive FIFO |
| txe_o | output | 1 | Transmit FIFO can take a 16-bit write |
| rxne_o | output | 1 | Receive threshold reached |
| ovr_o | output | 1 | Sticky receive overrun |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| nss_o | output | 1 | Active-low slave select |
| miso_i | input | 1 | Serial data in |

## Verification
The bound checker watches the bus timing on every cycle. It checks that SCK is idle low outside a frame, that SCK only rises while select is low, and that MOSI holds outside rising edges. It also checks that the overrun flag, once set, never clears. Byte ordering of packed accesses, masking of unused upper bits, zero padding, the threshold switch for odd frame counts, and the dropping of writes on a full FIFO depend on data values. Only the directed scenarios show these, using a serial slave model that captures MOSI and returns known MISO patterns.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;
  typedef logic [7:0] frame_t;

  // size-minus-one field to index of the first (MSB) bit; out-of-range sizes clamp to 8 bits
  function automatic logic [2:0] top_bit(input logic [3:0] dsz);
    return dsz[3] ? 3'd7 : dsz[2:0];
  endfunction
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    push_n_i,
  input  logic [15:0]   push_d_i,
  input  logic [1:0]    pop_n_i,
  output logic [CW-1:0] cnt_o,
  output logic [15:0]   head_o
);
  import spi_pack_pkg::*;

  frame_t        mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_n_i != 2'd0) mem[wr_ptr] <= push_d_i[7:0];
      if (push_n_i == 2'd2) mem[wr_ptr + AW'(1)] <= push_d_i[15:8];
      wr_ptr <= wr_ptr + AW'(push_n_i);
      rd_ptr <= rd_ptr + AW'(pop_n_i);
      cnt    <= cnt + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  assign cnt_o  = cnt;
  assign head_o = {mem[rd_ptr + AW'(1)], mem[rd_ptr]};
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int HALF_DIV = 2,
  localparam int DW = $clog2(HALF_DIV + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] top_bit_i,
  input  logic       tx_vld_i,
  input  logic [7:0] tx_byte_i,
  output logic       tx_pop_o,
  output logic       rx_push_o,
  output logic [7:0] rx_byte_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       nss_o,
  input  logic       miso_i
);
  logic          busy, sck, mosi, rx_push;
  logic [DW-1:0] div;
  logic [2:0]    bit_idx;
  logic [7:0]    txb, rxb, rx_byte;
  logic          tick, frame_end;

  assign tick      = (div == DW'(HALF_DIV - 1));
  assign frame_end = busy && tick && sck && (bit_idx == 3'd0);
  assign tx_pop_o  = tx_vld_i && (!busy || frame_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      div     <= '0;
      bit_idx <= '0;
      txb     <= '0;
      rxb     <= '0;
      rx_push <= 1'b0;
      rx_byte <= '0;
    end else begin
      rx_push <= 1'b0;
      if (!busy) begin
        if (tx_vld_i) begin
          busy    <= 1'b1;
          txb     <= tx_byte_i;
          bit_idx <= top_bit_i;
          rxb     <= '0;
          div     <= '0;
        end
      end else if (!tick) begin
        div <= div + DW'(1);
      end else begin
        div <= '0;
        if (!sck) begin
          sck  <= 1'b1;          // launch edge
          mosi <= txb[bit_idx];
        end else begin
          sck <= 1'b0;           // capture edge
          rxb <= {rxb[6:0], miso_i};
          if (bit_idx == 3'd0) begin
            rx_push <= 1'b1;
            rx_byte <= {rxb[6:0], miso_i};
            if (tx_vld_i) begin
              txb     <= tx_byte_i;
              bit_idx <= top_bit_i;
              rxb     <= '0;
            end else begin
              busy <= 1'b0;
            end
          end else begin
            bit_idx <= bit_idx - 3'd1;
          end
        end
      end
    end
  end

  assign sck_o     = sck;
  assign mosi_o    = mosi;
  assign nss_o     = !busy;
  assign rx_push_o = rx_push;
  assign rx_byte_o = rx_byte;
endmodule

// File: rtl/spi_pack_dp.sv
module spi_pack_dp #(
  parameter int DEPTH    = 4,
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  cfg_dsz_i,
  input  logic        cfg_rx_qtr_i,
  input  logic        wr_en_i,
  input  logic        wr_wide_i,
  input  logic [15:0] wr_data_i,
  input  logic        rd_en_i,
  input  logic        rd_wide_i,
  output logic [15:0] rd_data_o,
  output logic        txe_o,
  output logic        rxne_o,
  output logic        ovr_o,
  output logic        sck_o,
  output logic        mosi_o,
  output logic        nss_o,
  input  logic        miso_i
);
  import spi_pack_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic [15:0]   tx_head, rx_head;
  logic [1:0]    tx_push_n, rx_push_n, rx_pop_n;
  logic          wr_ok, rd_ok, eng_pop, eng_rx_push, rx_ok, ovr;
  logic [7:0]    eng_rx_byte;

  assign tx_free   = CW'(DEPTH) - tx_cnt;
  assign wr_ok     = wr_en_i && (wr_wide_i ? (tx_free >= CW'(2)) : (tx_free >= CW'(1)));
  assign tx_push_n = wr_ok ? (wr_wide_i ? 2'd2 : 2'd1) : 2'd0;

  assign rd_ok     = rd_en_i && (rd_wide_i ? (rx_cnt >= CW'(2)) : (rx_cnt >= CW'(1)));
  assign rx_pop_n  = rd_ok ? (rd_wide_i ? 2'd2 : 2'd1) : 2'd0;
  assign rx_ok     = eng_rx_push && (rx_cnt < CW'(DEPTH));
  assign rx_push_n = {1'b0, rx_ok};

  spi_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_n_i (tx_push_n),
    .push_d_i (wr_data_i),
    .pop_n_i  ({1'b0, eng_pop}),
    .cnt_o    (tx_cnt),
    .head_o   (tx_head)
  );

  spi_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_n_i (rx_push_n),
    .push_d_i ({8'h00, eng_rx_byte}),
    .pop_n_i  (rx_pop_n),
    .cnt_o    (rx_cnt),
    .head_o   (rx_head)
  );

  spi_shift_engine #(.HALF_DIV(HALF_DIV)) u_engine (
    .clk_i, .rst_ni,
    .top_bit_i (top_bit(cfg_dsz_i)),
    .tx_vld_i  (tx_cnt != '0),
    .tx_byte_i (tx_head[7:0]),
    .tx_pop_o  (eng_pop),
    .rx_push_o (eng_rx_push),
    .rx_byte_o (eng_rx_byte),
    .sck_o, .mosi_o, .nss_o, .miso_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr <= 1'b0;
    else if (eng_rx_push && !rx_ok) ovr <= 1'b1;
  end

  assign ovr_o     = ovr;
  assign txe_o     = tx_free >= CW'(2);
  assign rxne_o    = cfg_rx_qtr_i ? (rx_cnt >= CW'(1)) : (rx_cnt >= CW'(2));
  assign rd_data_o = rd_wide_i ? rx_head : {8'h00, rx_head[7:0]};
endmodule

// File: rtl/spi_pack_dp_chk.sv
module spi_pack_dp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sck_o,
  input logic mosi_o,
  input logic nss_o,
  input logic ovr_o
);
  p_sck_idle_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nss_o |-> !sck_o);

  p_sck_rise_selected_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> !nss_o);

  p_mosi_launch_only_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(sck_o) |-> $stable(mosi_o));

  p_ovr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovr_o) |-> ovr_o);
endmodule

bind spi_pack_dp spi_pack_dp_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .sck_o (sck_o),
  .mosi_o (mosi_o), .nss_o (nss_o), .ovr_o (ovr_o)
);

// File: tb/spi_pack_dp_tb.sv
module spi_pack_dp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_dsz = 4'd3;
  logic        cfg_qtr = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0, rd_en = 1'b0, rd_wide = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        txe, rxne, ovr, sck, mosi, nss;
  logic        miso = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] sres [16];
  logic [7:0] caps [16];
  int fr = 0, bitn = 0;
  logic [7:0] cap = '0;

  always #5 clk = ~clk;

  spi_pack_dp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_dsz_i(cfg_dsz), .cfg_rx_qtr_i(cfg_qtr),
    .wr_en_i(wr_en), .wr_wide_i(wr_wide), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_wide_i(rd_wide), .rd_data_o(rd_data),
    .txe_o(txe), .rxne_o(rxne), .ovr_o(ovr),
    .sck_o(sck), .mosi_o(mosi), .nss_o(nss), .miso_i(miso)
  );

  // serial slave: drives MISO on rising SCK, captures MOSI on falling SCK
  initial begin
    forever begin
      @(sck);
      if (sck) begin
        miso = sres[fr][int'(cfg_dsz) - bitn];
      end else begin
        cap = {cap[6:0], mosi};
        bitn++;
        if (bitn == int'(cfg_dsz) + 1) begin
          caps[fr] = cap;
          fr++;
          bitn = 0;
          cap = '0;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic slave_clear();
    fr = 0; bitn = 0; cap = '0;
    for (int i = 0; i < 16; i++) caps[i] = '0;
  endtask

  task automatic host_wr(input logic wide, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_wide = wide; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic wide, input logic [15:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_wide = wide;
    #1;
    chk(req, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    while (fr < n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 txe", 16'(txe), 16'd1);
    chk("R1 rxne", 16'(rxne), 16'd0);
    chk("R1 ovr", 16'(ovr), 16'd0);
    chk("R1 nss", 16'(nss), 16'd1);
    chk("R1 sck", 16'(sck), 16'd0);
  endtask

  // 4-bit frames, packed write with junk in the upper nibble
  task automatic t_pair4();
    @(negedge clk);
    cfg_dsz = 4'd3; cfg_qtr = 1'b0;
    slave_clear();
    sres[0] = 8'hFB; sres[1] = 8'h3C;
    host_wr(1'b1, 16'h04FA);
    wait_frames(1);
    chk("R6 one byte, pair threshold", 16'(rxne), 16'd0);
    wait_frames(2);
    chk("R6 two bytes", 16'(rxne), 16'd1);
    chk("R2 R3 first frame low byte masked", 16'(caps[0]), 16'h000A);
    chk("R2 second frame high byte", 16'(caps[1]), 16'h0004);
    host_rd(1'b1, 16'h0C0B, "R4 R5 zero padded packed read");
    #1;
    chk("R6 after read", 16'(rxne), 16'd0);
  endtask

  // odd count of 8-bit frames: narrow write, threshold switch
  task automatic t_odd8();
    @(negedge clk);
    cfg_dsz = 4'd7; cfg_qtr = 1'b0;
    slave_clear();
    sres[0] = 8'h11; sres[1] = 8'h22; sres[2] = 8'h33;
    host_wr(1'b1, 16'h5AC3);
    host_wr(1'b0, 16'hAA7E);
    wait_frames(2);
    chk("R6 pair ready", 16'(rxne), 16'd1);
    host_rd(1'b1, 16'h2211, "R5 wide read order");
    wait_frames(3);
    chk("R6 single byte under pair threshold", 16'(rxne), 16'd0);
    @(negedge clk);
    cfg_qtr = 1'b1;
    #1;
    chk("R6 quarter threshold", 16'(rxne), 16'd1);
    host_rd(1'b0, 16'h0033, "R5 narrow read");
    chk("R2 frame0", 16'(caps[0]), 16'h00C3);
    chk("R2 frame1", 16'(caps[1]), 16'h005A);
    chk("R7 narrow write frame", 16'(caps[2]), 16'h007E);
    repeat (60) @(negedge clk);
    chk("R7 only one byte pushed", 16'(fr), 16'd3);
    chk("R11 select released", 16'(nss), 16'd1);
  endtask

  // fill TX FIFO, drop writes, overrun RX FIFO
  task automatic t_full6();
    @(negedge clk);
    cfg_dsz = 4'd5; cfg_qtr = 1'b0;
    slave_clear();
    for (int i = 0; i < 6; i++) sres[i] = 8'(i + 1);
    host_wr(1'b1, 16'h2A15);
    chk("R8 two free after first pair", 16'(txe), 16'd1);
    host_wr(1'b1, 16'h0C33);
    chk("R8 one free", 16'(txe), 16'd0);
    host_wr(1'b1, 16'h1111);
    host_wr(1'b0, 16'h0007);
    host_wr(1'b0, 16'h0009);
    wait_frames(5);
    repeat (60) @(negedge clk);
    chk("R9 dropped writes not sent", 16'(fr), 16'd5);
    chk("R2 f0", 16'(caps[0]), 16'h0015);
    chk("R2 f1", 16'(caps[1]), 16'h002A);
    chk("R2 f2", 16'(caps[2]), 16'h0033);
    chk("R2 f3", 16'(caps[3]), 16'h000C);
    chk("R9 narrow fit", 16'(caps[4]), 16'h0007);
    chk("R10 overrun flag", 16'(ovr), 16'd1);
    host_rd(1'b1, 16'h0201, "R10 first pair kept");
    host_rd(1'b1, 16'h0403, "R10 second pair kept");
    @(negedge clk);
    cfg_qtr = 1'b1;
    #1;
    chk("R10 fifth frame discarded", 16'(rxne), 16'd0);
    chk("R10 flag still set", 16'(ovr), 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) sres[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_pair4();
    t_odd8();
    t_full6();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule